// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block keeps the fetch address of a small pipelined core. Each instruction cycle spans four system-clock phases, and the fetch of one instruction overlaps the execution of the one before it. The register `pc` always holds the address being fetched. At the end of the fourth phase the block chooses the next fetch address. The choices are a plain increment, a taken conditional skip, a write to the low address byte, a jump or call target, a return address from a six-entry hardware stack, or a fixed interrupt vector.

Any change to the address other than the plain increment makes the word already fetched invalid. When that happens the block raises `flush` for the whole next instruction cycle, which becomes a dummy cycle. During that dummy cycle the block ignores the decoded control code and the interrupt requests and simply steps the address. Calls and accepted interrupts push the pending fetch address, which is the address of the next instruction. Returns pop it.

The instruction decoder supplies `ctrl`, `tgt_addr`, `pcl_data` and `skip_hit`, and must hold them steady through the fourth phase. The interrupt controller supplies `irq_req` and clears a request when it sees the matching `irq_ack` strobe. A parameter narrows the address to 10 bits for a 1024-word program memory.

Top module: `pc_seq_unit`

## Requirements
- R1: While `rst` is high and afterwards until the first update, `pc` is 0, `phase` is 0, `flush` is 1 and `stk_full` is 0. The first instruction cycle after reset is therefore a dummy cycle.
- R2: `phase` counts 0,1,2,3,0,... on every clock. `pc` and `flush` change only on the clock edge that ends phase 3, and the strobes `stk_push`, `stk_pop` and `irq_ack` can be high only during phase 3.
- R3: With `ctrl`=0 (step) in a normal cycle and no interrupt accepted, `pc` becomes `pc`+1 modulo 2^PC_W and `flush` becomes 0.
- R4: With `ctrl`=1 (conditional skip) and `skip_hit`=1, `pc` becomes `pc`+1 and `flush` becomes 1. The skipped word is never executed, so the next executed address is the skipping instruction's address plus two. With `skip_hit`=0 the cycle behaves exactly like a step.
- R5: With `ctrl`=2 (low-byte write), `pc` bits 7..0 take `pcl_data`, the bits above 7 keep their value, and `flush` becomes 1.
- R6: With `ctrl`=3 (jump), `pc` takes `tgt_addr` and `flush` becomes 1.
- R7: With `ctrl`=4 (call) and the stack not full, the current `pc` is pushed (`stk_push` is high during phase 3), `pc` takes `tgt_addr`, and `flush` becomes 1.
- R8: With `ctrl`=5 (return), `pc` takes the most recently pushed address, the entry is removed (`stk_pop` is high during phase 3), and `flush` becomes 1. Nested calls and interrupts return in LIFO order.
- R9: In a cycle with `flush`=1, `ctrl`, `skip_hit` and `irq_req` have no effect. `pc` steps by one, no strobe fires, and `flush` returns to 0.
- R10: An interrupt is accepted only in a normal cycle with `ctrl`=0 and the stack not full. Request bit 0 is external and goes to vector 0x004. Bit 1 is the timer and goes to 0x008. Bit 2 is A/D and goes to 0x00C. The lowest set bit wins. Acceptance pushes `pc`, raises the matching one-hot `irq_ack` bit during phase 3, and sets `flush`.
- R11: `stk_full` is 1 once six entries are held. While it is 1, requests are not accepted and a call still jumps to `tgt_addr` but pushes nothing. The stack contents are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 3 | Decoded PC control: 0 step, 1 skip, 2 low-byte write, 3 jump, 4 call, 5 return |
| skip_hit | input | 1 | Skip condition true |
| tgt_addr | input | PC_W | Jump/call address field |
| pcl_data | input | 8 | Byte written to the low PC byte |
| irq_req | input | 3 | Pending requests: [0] external, [1] timer, [2] A/D |
| pc | output | PC_W | Current fetch address |
| phase | output | 2 | Phase within the instruction cycle (0..3) |
| flush | output | 1 | Current cycle is a dummy cycle; discard the fetched word |
| stk_push | output | 1 | Return address pushed this update |
| stk_pop | output | 1 | Return address popped this update |
| stk_full | output | 1 | All six stack entries used |
| irq_ack | output | 3 | One-hot acceptance strobe, same bit order as `irq_req` |

## Verification
A vector table runs a single sequence that covers each control code. It includes a skip with the condition both false and true, which separates the flushing skip from a plain step. It includes a jump control code presented during the dummy cycle, which shows the code is ignored there. Low-byte writes use a high page, which exposes any loss of the upper bits. All three interrupt requests are raised at once and then dropped one by one, which fixes both the priority order and the vector mapping. Nested returns show the LIFO order. A jump to the last address followed by a step exposes the wrap. Directed tests then fill the stack through six calls, offer an interrupt and a seventh call while it is full, and unwind it, which shows that nothing was overwritten. A reset in the middle of the run comes last.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

    localparam int PHASES = 4;
    localparam int PH_W   = $clog2(PHASES);
    localparam int IRQ_N  = 3;
    localparam int IRQ_IW = $clog2(IRQ_N);

    typedef enum logic [2:0] {
        CTL_STEP = 3'd0,
        CTL_SKIP = 3'd1,
        CTL_PCLW = 3'd2,
        CTL_JMP  = 3'd3,
        CTL_CALL = 3'd4,
        CTL_RET  = 3'd5
    } pc_ctl_e;

    // Vector address of request index idx: 4 * (idx + 1)
    function automatic logic [7:0] vec_of(input logic [IRQ_IW-1:0] idx);
        logic [7:0] n;
        n = 8'(idx) + 8'd1;
        return {n[5:0], 2'b00};
    endfunction

endpackage

// File: rtl/pc_phase_gen.sv
module pc_phase_gen
    import pc_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase,
    output logic            upd
);
    always_ff @(posedge clk) begin
        if (rst)
            phase <= '0;
        else if (phase == PH_W'(PHASES - 1))
            phase <= '0;
        else
            phase <= phase + PH_W'(1);
    end

    assign upd = (phase == PH_W'(PHASES - 1));
endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
    parameter int DEPTH = 6,
    parameter int W     = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         full,
    output logic         empty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_m1;

    assign full   = (cnt == CW'(DEPTH));
    assign empty  = (cnt == '0);
    assign cnt_m1 = cnt - CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (push && !full) begin
            mem[IW'(cnt)] <= din;
            cnt           <= cnt + CW'(1);
        end else if (pop && !empty) begin
            cnt <= cnt_m1;
        end
    end

    assign top = empty ? mem[0] : mem[IW'(cnt_m1)];
endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel
    import pc_seq_pkg::*;
#(
    parameter int PC_W = 11
) (
    input  logic [PC_W-1:0]  pc,
    input  pc_ctl_e          ctl,
    input  logic             skip_hit,
    input  logic [PC_W-1:0]  tgt_addr,
    input  logic [7:0]       pcl_data,
    input  logic [IRQ_N-1:0] irq_req,
    input  logic             flush,
    input  logic             full,
    input  logic             empty,
    input  logic [PC_W-1:0]  top,
    output logic [PC_W-1:0]  nxt_pc,
    output logic             nxt_flush,
    output logic             push,
    output logic             pop,
    output logic [IRQ_N-1:0] ack
);
    logic [PC_W-1:0]   inc_pc;
    logic [PC_W-1:0]   pcl_pc;
    logic [IRQ_IW-1:0] win;
    logic              any_req;

    assign inc_pc = pc + PC_W'(1);

    generate
        if (PC_W > 8) begin : g_page
            assign pcl_pc = {pc[PC_W-1:8], pcl_data};
        end else begin : g_flat
            assign pcl_pc = pcl_data[PC_W-1:0];
        end
    endgenerate

    // Lowest set request bit has the highest priority
    always_comb begin
        win     = '0;
        any_req = 1'b0;
        for (int i = IRQ_N - 1; i >= 0; i--) begin
            if (irq_req[i]) begin
                win     = IRQ_IW'(i);
                any_req = 1'b1;
            end
        end
    end

    always_comb begin
        nxt_pc    = inc_pc;
        nxt_flush = 1'b0;
        push      = 1'b0;
        pop       = 1'b0;
        ack       = '0;
        if (!flush) begin
            case (ctl)
                CTL_SKIP: nxt_flush = skip_hit;
                CTL_PCLW: begin
                    nxt_pc    = pcl_pc;
                    nxt_flush = 1'b1;
                end
                CTL_JMP: begin
                    nxt_pc    = tgt_addr;
                    nxt_flush = 1'b1;
                end
                CTL_CALL: begin
                    nxt_pc    = tgt_addr;
                    nxt_flush = 1'b1;
                    push      = !full;
                end
                CTL_RET: begin
                    nxt_pc    = top;
                    nxt_flush = 1'b1;
                    pop       = !empty;
                end
                default: begin
                    if (any_req && !full) begin
                        nxt_pc    = PC_W'(vec_of(win));
                        nxt_flush = 1'b1;
                        push      = 1'b1;
                        ack[win]  = 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/pc_seq_unit.sv
module pc_seq_unit
    import pc_seq_pkg::*;
#(
    parameter int PC_W      = 11,
    parameter int STK_DEPTH = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       ctrl,
    input  logic             skip_hit,
    input  logic [PC_W-1:0]  tgt_addr,
    input  logic [7:0]       pcl_data,
    input  logic [IRQ_N-1:0] irq_req,
    output logic [PC_W-1:0]  pc,
    output logic [PH_W-1:0]  phase,
    output logic             flush,
    output logic             stk_push,
    output logic             stk_pop,
    output logic             stk_full,
    output logic [IRQ_N-1:0] irq_ack
);
    logic            upd;
    logic [PC_W-1:0] nxt_pc;
    logic            nxt_flush;
    logic            push_req;
    logic            pop_req;
    logic [IRQ_N-1:0] ack_req;
    logic [PC_W-1:0] stk_top;
    logic            stk_empty;
    pc_ctl_e         ctl;

    assign ctl = pc_ctl_e'(ctrl);

    pc_phase_gen u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .upd   (upd)
    );

    pc_next_sel #(.PC_W(PC_W)) u_sel (
        .pc        (pc),
        .ctl       (ctl),
        .skip_hit  (skip_hit),
        .tgt_addr  (tgt_addr),
        .pcl_data  (pcl_data),
        .irq_req   (irq_req),
        .flush     (flush),
        .full      (stk_full),
        .empty     (stk_empty),
        .top       (stk_top),
        .nxt_pc    (nxt_pc),
        .nxt_flush (nxt_flush),
        .push      (push_req),
        .pop       (pop_req),
        .ack       (ack_req)
    );

    assign stk_push = upd && push_req;
    assign stk_pop  = upd && pop_req;
    assign irq_ack  = upd ? ack_req : '0;

    pc_ret_stack #(.DEPTH(STK_DEPTH), .W(PC_W)) u_stack (
        .clk   (clk),
        .rst   (rst),
        .push  (stk_push),
        .pop   (stk_pop),
        .din   (pc),
        .top   (stk_top),
        .full  (stk_full),
        .empty (stk_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= '0;
            flush <= 1'b1;
        end else if (upd) begin
            pc    <= nxt_pc;
            flush <= nxt_flush;
        end
    end
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk
    import pc_seq_pkg::*;
#(
    parameter int PC_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       ctrl,
    input logic [7:0]       pcl_data,
    input logic [IRQ_N-1:0] irq_req,
    input logic [PC_W-1:0]  pc,
    input logic [PH_W-1:0]  phase,
    input logic             flush,
    input logic             stk_push,
    input logic             stk_pop,
    input logic             stk_full,
    input logic [IRQ_N-1:0] irq_ack
);
    localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (phase == PH_W'($past(phase) + PH_W'(1))));

    // R2
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != LAST) |=> $stable(pc) && $stable(flush));

    // R2
    strobe_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != LAST) |-> !stk_push && !stk_pop && (irq_ack == '0));

    // R3
    step_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == LAST && !flush && ctrl == 3'd0 && (irq_req == '0 || stk_full))
        |=> (pc == PC_W'($past(pc) + PC_W'(1))) && !flush);

    // R5
    pcl_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == LAST && !flush && ctrl == 3'd2)
        |=> (pc[7:0] == $past(pcl_data)) && (pc[PC_W-1:8] == $past(pc[PC_W-1:8])) && flush);

    // R9
    flush_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        flush |-> !stk_push && !stk_pop && (irq_ack == '0));

    // R9
    flush_end_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == LAST && flush) |=> !flush && (pc == PC_W'($past(pc) + PC_W'(1))));

    // R10
    ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_ack));

    // R10
    ack_ext_chk: assert property (@(posedge clk) disable iff (rst)
        irq_ack[0] |=> (pc == PC_W'(4)) && flush);

    // R10
    ack_push_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_ack != '0) |-> stk_push);

    // R11
    full_block_chk: assert property (@(posedge clk) disable iff (rst)
        stk_full |-> (irq_ack == '0) && !stk_push);

    // R8
    no_both_chk: assert property (@(posedge clk) disable iff (rst)
        !(stk_push && stk_pop));
endmodule

bind pc_seq_unit pc_seq_chk #(.PC_W(PC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .pcl_data (pcl_data),
    .irq_req  (irq_req),
    .pc       (pc),
    .phase    (phase),
    .flush    (flush),
    .stk_push (stk_push),
    .stk_pop  (stk_pop),
    .stk_full (stk_full),
    .irq_ack  (irq_ack)
);

// File: tb/pc_seq_unit_tb.sv
module pc_seq_unit_tb;
    localparam int PC_W = 11;
    localparam int NV   = 31;
    localparam int VW   = 43;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [2:0]      ctrl = 3'd0;
    logic            skip_hit = 1'b0;
    logic [PC_W-1:0] tgt_addr = '0;
    logic [7:0]      pcl_data = 8'h00;
    logic [2:0]      irq_req = 3'b000;
    logic [PC_W-1:0] pc;
    logic [1:0]      phase;
    logic            flush;
    logic            stk_push;
    logic            stk_pop;
    logic            stk_full;
    logic [2:0]      irq_ack;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pc_seq_unit u_dut (
        .clk(clk), .rst(rst), .ctrl(ctrl), .skip_hit(skip_hit),
        .tgt_addr(tgt_addr), .pcl_data(pcl_data), .irq_req(irq_req),
        .pc(pc), .phase(phase), .flush(flush), .stk_push(stk_push),
        .stk_pop(stk_pop), .stk_full(stk_full), .irq_ack(irq_ack)
    );

    function automatic logic [VW-1:0] mk(input logic [2:0] c, input logic s,
        input logic [10:0] a, input logic [7:0] p, input logic [2:0] i,
        input logic [10:0] epc, input logic ef, input logic eps,
        input logic epp, input logic [2:0] eack);
        return {c, s, a, p, i, epc, ef, eps, epp, eack};
    endfunction

    localparam logic [VW-1:0] VEC [NV] = '{
        mk(3'd3, 0, 11'h123, 8'h00, 3'b000, 11'h001, 0, 0, 0, 3'b000), // R9 jump ignored in dummy cycle
        mk(3'd0, 0, 11'h000, 8'h00, 3'b000, 11'h002, 0, 0, 0, 3'b000), // R3
        mk(3'd1, 0, 11'h000, 8'h00, 3'b000, 11'h003, 0, 0, 0, 3'b000), // R4 not taken
        mk(3'd1, 1, 11'h000, 8'h00, 3'b000, 11'h004, 1, 0, 0, 3'b000), // R4 taken
        mk(3'd0, 0, 11'h000, 8'h00, 3'b000, 11'h005, 0, 0, 0, 3'b000), // R9
        mk(3'd3, 0, 11'h5A0, 8'h00, 3'b000, 11'h5A0, 1, 0, 0, 3'b000), // R6
        mk(3'd0, 0, 11'h000, 8'h00, 3'b000, 11'h5A1, 0, 0, 0, 3'b000), // R9
        mk(3'd4, 0, 11'h7F0, 8'h00, 3'b000, 11'h7F0, 1, 1, 0, 3'b000), // R7
        mk(3'd0, 0, 11'h000, 8'h00, 3'b000, 11'h7F1, 0, 0, 0, 3'b000), // R9
        mk(3'd2, 0, 11'h000, 8'h22, 3'b000, 11'h722, 1, 0, 0, 3'b000), // R5
        mk(3'd0, 0, 11'h000, 8'h00, 3'b000, 11'h723, 0, 0, 0, 3'b000), // R9
        mk(3'd5, 0, 11'h000, 8'h00, 3'b000, 11'h5A1, 1, 0, 1, 3'b000), // R8
        mk(3'd0, 0, 11'h000, 8'h00, 3'b000, 11'h5A2, 0, 0, 0, 3'b000), // R9
        mk(3'd0, 0, 11'h000, 8'h00, 3'b111, 11'h004, 1, 1, 0, 3'b001), // R10 ext wins
        mk(3'd0, 0, 11'h000, 8'h00, 3'b110, 11'h005, 0, 0, 0, 3'b000), // R9 irq ignored
        mk(3'd0, 0, 11'h000, 8'h00, 3'b110, 11'h008, 1, 1, 0, 3'b010), // R10 timer wins
        mk(3'd0, 0, 11'h000, 8'h00, 3'b100, 11'h009, 0, 0, 0, 3'b000), // R9
        mk(3'd0, 0, 11'h000, 8'h00, 3'b100, 11'h00C, 1, 1, 0, 3'b100), // R10 A/D
        mk(3'd0, 0, 11'h000, 8'h00, 3'b000, 11'h00D, 0, 0, 0, 3'b000), // R9
        mk(3'd5, 0, 11'h000, 8'h00, 3'b000, 11'h009, 1, 0, 1, 3'b000), // R8 LIFO
        mk(3'd0, 0, 11'h000, 8'h00, 3'b000, 11'h00A, 0, 0, 0, 3'b000),
        mk(3'd5, 0, 11'h000, 8'h00, 3'b000, 11'h005, 1, 0, 1, 3'b000), // R8 LIFO
        mk(3'd0, 0, 11'h000, 8'h00, 3'b000, 11'h006, 0, 0, 0, 3'b000),
        mk(3'd5, 0, 11'h000, 8'h00, 3'b000, 11'h5A2, 1, 0, 1, 3'b000), // R8 LIFO
        mk(3'd0, 0, 11'h000, 8'h00, 3'b000, 11'h5A3, 0, 0, 0, 3'b000),
        mk(3'd3, 0, 11'h3FF, 8'h00, 3'b001, 11'h3FF, 1, 0, 0, 3'b000), // R10 not with jump
        mk(3'd0, 0, 11'h000, 8'h00, 3'b000, 11'h400, 0, 0, 0, 3'b000),
        mk(3'd0, 0, 11'h000, 8'h00, 3'b000, 11'h401, 0, 0, 0, 3'b000), // R3
        mk(3'd3, 0, 11'h7FF, 8'h00, 3'b000, 11'h7FF, 1, 0, 0, 3'b000), // R6
        mk(3'd0, 0, 11'h000, 8'h00, 3'b000, 11'h000, 0, 0, 0, 3'b000), // R3 wrap
        mk(3'd0, 0, 11'h000, 8'h00, 3'b000, 11'h001, 0, 0, 0, 3'b000)  // R3
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Called at a negedge in phase 0; returns at the negedge of the next phase 0.
    task automatic step(input logic [2:0] c, input logic s, input logic [10:0] a,
        input logic [7:0] p, input logic [2:0] i, output logic o_push,
        output logic o_pop, output logic [2:0] o_ack);
        ctrl = c; skip_hit = s; tgt_addr = a; pcl_data = p; irq_req = i;
        repeat (3) @(negedge clk);
        o_push = stk_push; o_pop = stk_pop; o_ack = irq_ack;
        @(negedge clk);
    endtask

    initial begin
        #3000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic            sp, sq;
        logic [2:0]      sa;
        logic [10:0]     cur;
        logic [10:0]     ms [6];
        int              n;

        repeat (3) @(negedge clk);
        // R1 reset state during reset
        check("R1 pc in reset", int'(pc), 0);
        check("R1 flush in reset", int'(flush), 1);
        rst = 1'b0;
        check("R1 phase after reset", int'(phase), 0);
        check("R1 full after reset", int'(stk_full), 0);

        for (int k = 0; k < NV; k++) begin
            logic [VW-1:0] v;
            v = VEC[k];
            step(v[42:40], v[39], v[38:28], v[27:20], v[19:17], sp, sq, sa);
            check($sformatf("R2 row %0d push", k), int'(sp), int'(v[4]));
            check($sformatf("R2 row %0d pop", k), int'(sq), int'(v[3]));
            check($sformatf("R10 row %0d ack", k), int'(sa), int'(v[2:0]));
            check($sformatf("R3 row %0d pc", k), int'(pc), int'(v[16:6]));
            check($sformatf("R9 row %0d flush", k), int'(flush), int'(v[5]));
            check($sformatf("R2 row %0d phase", k), int'(phase), 0);
        end

        // R11: fill the stack with six calls
        cur = 11'h001;
        n = 0;
        for (int k = 0; k < 6; k++) begin
            logic [10:0] t;
            t = 11'h100 + 11'(k * 16);
            step(3'd4, 0, t, 8'h00, 3'b000, sp, sq, sa);
            check("R7 call push", int'(sp), 1);
            check("R7 call target", int'(pc), int'(t));
            ms[n] = cur; n++;
            cur = t;
            step(3'd0, 0, 11'h000, 8'h00, 3'b000, sp, sq, sa);
            cur = cur + 11'd1;
            check("R9 after call", int'(pc), int'(cur));
        end
        check("R11 full after six", int'(stk_full), 1);

        step(3'd0, 0, 11'h000, 8'h00, 3'b001, sp, sq, sa);
        cur = cur + 11'd1;
        check("R11 irq blocked ack", int'(sa), 0);
        check("R11 irq blocked pc", int'(pc), int'(cur));
        check("R11 irq blocked flush", int'(flush), 0);

        step(3'd4, 0, 11'h7A0, 8'h00, 3'b000, sp, sq, sa);
        check("R11 full call no push", int'(sp), 0);
        check("R11 full call target", int'(pc), int'(11'h7A0));
        step(3'd0, 0, 11'h000, 8'h00, 3'b000, sp, sq, sa);

        for (int k = 0; k < 6; k++) begin
            step(3'd5, 0, 11'h000, 8'h00, 3'b000, sp, sq, sa);
            n--;
            check("R8 unwind pop", int'(sq), 1);
            check("R8 unwind pc", int'(pc), int'(ms[n]));
            if (k == 0) check("R11 full clears", int'(stk_full), 0);
            step(3'd0, 0, 11'h000, 8'h00, 3'b000, sp, sq, sa);
        end

        // R5 on page 0: low byte from data, upper bits zero kept
        step(3'd2, 0, 11'h000, 8'hEE, 3'b000, sp, sq, sa);
        check("R5 page0 write", int'(pc), int'(11'h0EE));

        // R1 reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid reset pc", int'(pc), 0);
        check("R1 mid reset flush", int'(flush), 1);
        check("R1 mid reset phase", int'(phase), 0);
        check("R1 mid reset full", int'(stk_full), 0);
        rst = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule